// File: doc/BRIEF.md
# Split 16-bit Timer/Counter with Capture

This block is a 16-bit timer/counter made of two 8-bit halves that can run on their own or be chained into one 16-bit count. A programmable prescaler turns the system clock into a periodic tick that drives the timer modes. Two external event inputs can advance the halves instead of the tick. Each half has a capture input and a capture register. A two-bit mode field picks one of four arrangements: two prescaled 8-bit timers, a prescaled 8-bit timer beside an 8-bit event counter, a chained 16-bit prescaled timer, or a chained 16-bit event counter.

Each half has its own match register. When a half that sits at its match value is told to advance, it returns to zero. That return pulses a match output for one cycle and sets a sticky interrupt flag. Software reaches the configuration, match, flag, capture and count registers through a plain single-cycle write port and a combinational read port. All event and capture inputs pass through a synchroniser and a rising-edge detector, so they may be fully asynchronous to the clock.

Top module: `split_timer16`

## Requirements
- R1: After reset the counts, prescaler, captures and flags are zero, both match registers hold 0xFF, the prescale register holds 0, and the control register holds 0 (mode 0, both halves stopped).
- R2: The prescaler gives one tick every PRESC+1 clocks, counted from the last control write. A running timer half advances by one on each tick.
- R3: Mode 0 (control bits [1:0] = 0): each half is an independent prescaled 8-bit timer. The low half is enabled by control bit 2 and the high half by control bit 3.
- R4: Mode 1 (control bits [1:0] = 1): the low half is a prescaled timer. The high half counts rising edges of evt_hi_i while control bit 3 is set.
- R5: Mode 2 (control bits [1:0] = 2): the low half is a prescaled timer enabled by bit 2. The high half advances only in a cycle where the low half reloads from its match value. Bit 3 has no effect.
- R6: Mode 3 (control bits [1:0] = 3): the low half counts rising edges of evt_lo_i while bit 2 is set. The high half chains as in mode 2, and evt_hi_i is ignored.
- R7: A half that sits at its match value and is told to advance loads zero instead. In the following cycle its match output is high for exactly one cycle.
- R8: A reload sets that half's sticky flag, which drives irq_lo_o or irq_hi_o. Writing 1 to bit 0 (low) or bit 1 (high) of address 4 clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R9: In modes 0 and 1, a cap_lo_i edge copies the low count into the low capture register, and a cap_hi_i edge copies the high count into the high capture register. In modes 2 and 3, a cap_lo_i edge copies both halves in the same cycle and cap_hi_i is ignored. The value captured is the count as it stood before that cycle's update.
- R10: An event or capture input that is held high for at least one clock and then low for at least one clock is acted on exactly once, however long it stays high. The action takes effect at the third rising clock edge after the input is first sampled high.
- R11: A write to the control register clears both counts and the prescaler in that cycle. The same write loads the mode from bits [1:0] and the run bits from bits 2 and 3.
- R12: Register map: 0 control, 1 prescale, 2 low match, 3 high match, 4 flags {high, low}, 5 low capture, 6 high capture, 7 low count, 8 high count. Addresses 5 to 8 are read-only, and an unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DW | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DW | Read data, combinational from rd_addr |
| evt_lo_i | input | 1 | External event input for the low half (mode 3) |
| evt_hi_i | input | 1 | External event input for the high half (mode 1) |
| cap_lo_i | input | 1 | Capture trigger for the low half, or for both halves in modes 2 and 3 |
| cap_hi_i | input | 1 | Capture trigger for the high half (modes 0 and 1) |
| irq_lo_o | output | 1 | Sticky low-half match flag |
| irq_hi_o | output | 1 | Sticky high-half match flag |
| match_lo_o | output | 1 | One-cycle pulse after a low-half reload |
| match_hi_o | output | 1 | One-cycle pulse after a high-half reload |

## Verification
The bench builds the block with its default 8-bit halves, 8-bit prescaler and 4-bit addresses. At these widths, match values as small as 1 to 3 and prescale values of 0 to 3 make both halves wrap, and make the chained high half wrap, within a few dozen cycles. Every mode, every reload, and every flag set and clear therefore comes up many times in a short run. Event and capture pulses one clock wide and several clocks wide test the edge detector against the narrowest stimulus the block accepts.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [1:0] {
    MODE_DUAL    = 2'd0,
    MODE_TMR_EVT = 2'd1,
    MODE_CASC    = 2'd2,
    MODE_EVT16   = 2'd3
  } tmr_mode_e;

  localparam int A_CTRL   = 0;
  localparam int A_PRESC  = 1;
  localparam int A_MLO    = 2;
  localparam int A_MHI    = 3;
  localparam int A_FLAGS  = 4;
  localparam int A_CAPLO  = 5;
  localparam int A_CAPHI  = 6;
  localparam int A_CNTLO  = 7;
  localparam int A_CNTHI  = 8;

  localparam int SRC_EVT_LO = 0;
  localparam int SRC_EVT_HI = 1;
  localparam int SRC_CAP_LO = 2;
  localparam int SRC_CAP_HI = 3;
  localparam int SRC_N      = 4;
endpackage

// File: rtl/tmr_sync_rise.sv
module tmr_sync_rise #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] din,
  output logic [N-1:0] rise
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], din[g]};
    end
    assign rise[g] = sh[1] & ~sh[2];
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] pc;
  assign tick = (pc == limit);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pc <= '0;
    else if (clr || tick) pc <= '0;
    else                 pc <= pc + 1'b1;
  end
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] match_val,
  output logic [W-1:0] cnt,
  output logic         hit
);
  assign hit = inc && (cnt == match_val);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (hit)   cnt <= '0;
    else if (inc)   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/split_timer16.sv
module split_timer16
  import tmr_pkg::*;
#(
  parameter int HALF_W = 8,
  parameter int PRE_W  = 8,
  parameter int ADDR_W = 4,
  localparam int DW    = (HALF_W > PRE_W) ? HALF_W : PRE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic              evt_lo_i,
  input  logic              evt_hi_i,
  input  logic              cap_lo_i,
  input  logic              cap_hi_i,
  output logic              irq_lo_o,
  output logic              irq_hi_o,
  output logic              match_lo_o,
  output logic              match_hi_o
);
  tmr_mode_e          mode_q;
  logic               run_lo_q, run_hi_q;
  logic [PRE_W-1:0]   presc_q;
  logic [HALF_W-1:0]  mlo_q, mhi_q;
  logic [HALF_W-1:0]  caplo_q, caphi_q;
  logic               flag_lo_q, flag_hi_q;
  logic               plo_q, phi_q;

  logic [HALF_W-1:0]  cnt_lo, cnt_hi;
  logic               inc_lo, inc_hi, hit_lo, hit_hi, tick;
  logic [SRC_N-1:0]   rise;
  logic               ctrl_wr, flag_wr, flag_clr_lo, flag_clr_hi;
  logic               wide_mode, grab_hi;

  assign ctrl_wr     = wr_en && (wr_addr == ADDR_W'(A_CTRL));
  assign flag_wr     = wr_en && (wr_addr == ADDR_W'(A_FLAGS));
  assign flag_clr_lo = flag_wr && wr_data[0];
  assign flag_clr_hi = flag_wr && wr_data[1];
  assign wide_mode   = mode_q[1];

  tmr_sync_rise #(.N(SRC_N)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({cap_hi_i, cap_lo_i, evt_hi_i, evt_lo_i}),
    .rise (rise)
  );

  tmr_prescale #(.W(PRE_W)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (ctrl_wr),
    .limit(presc_q),
    .tick (tick)
  );

  // advance enables per mode
  always_comb begin
    unique case (mode_q)
      MODE_DUAL: begin
        inc_lo = run_lo_q && tick;
        inc_hi = run_hi_q && tick;
      end
      MODE_TMR_EVT: begin
        inc_lo = run_lo_q && tick;
        inc_hi = run_hi_q && rise[SRC_EVT_HI];
      end
      MODE_CASC: begin
        inc_lo = run_lo_q && tick;
        inc_hi = hit_lo;
      end
      default: begin
        inc_lo = run_lo_q && rise[SRC_EVT_LO];
        inc_hi = hit_lo;
      end
    endcase
  end

  tmr_half #(.W(HALF_W)) u_lo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctrl_wr),
    .inc      (inc_lo),
    .match_val(mlo_q),
    .cnt      (cnt_lo),
    .hit      (hit_lo)
  );

  tmr_half #(.W(HALF_W)) u_hi (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (ctrl_wr),
    .inc      (inc_hi),
    .match_val(mhi_q),
    .cnt      (cnt_hi),
    .hit      (hit_hi)
  );

  // configuration registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= MODE_DUAL;
      run_lo_q <= 1'b0;
      run_hi_q <= 1'b0;
      presc_q  <= '0;
      mlo_q    <= '1;
      mhi_q    <= '1;
    end else if (wr_en) begin
      if (wr_addr == ADDR_W'(A_CTRL)) begin
        mode_q   <= tmr_mode_e'(wr_data[1:0]);
        run_lo_q <= wr_data[2];
        run_hi_q <= wr_data[3];
      end
      if (wr_addr == ADDR_W'(A_PRESC)) presc_q <= wr_data[PRE_W-1:0];
      if (wr_addr == ADDR_W'(A_MLO))   mlo_q   <= wr_data[HALF_W-1:0];
      if (wr_addr == ADDR_W'(A_MHI))   mhi_q   <= wr_data[HALF_W-1:0];
    end
  end

  // flags and match pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_lo_q <= 1'b0;
      flag_hi_q <= 1'b0;
      plo_q     <= 1'b0;
      phi_q     <= 1'b0;
    end else begin
      flag_lo_q <= hit_lo || (flag_lo_q && !flag_clr_lo);
      flag_hi_q <= hit_hi || (flag_hi_q && !flag_clr_hi);
      plo_q     <= hit_lo;
      phi_q     <= hit_hi;
    end
  end

  // capture: 16-bit modes latch both halves from the low trigger
  assign grab_hi = wide_mode ? rise[SRC_CAP_LO] : rise[SRC_CAP_HI];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      caplo_q <= '0;
      caphi_q <= '0;
    end else begin
      if (rise[SRC_CAP_LO]) caplo_q <= cnt_lo;
      if (grab_hi)          caphi_q <= cnt_hi;
    end
  end

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      ADDR_W'(A_CTRL):  rd_data = DW'({run_hi_q, run_lo_q, mode_q});
      ADDR_W'(A_PRESC): rd_data = DW'(presc_q);
      ADDR_W'(A_MLO):   rd_data = DW'(mlo_q);
      ADDR_W'(A_MHI):   rd_data = DW'(mhi_q);
      ADDR_W'(A_FLAGS): rd_data = DW'({flag_hi_q, flag_lo_q});
      ADDR_W'(A_CAPLO): rd_data = DW'(caplo_q);
      ADDR_W'(A_CAPHI): rd_data = DW'(caphi_q);
      ADDR_W'(A_CNTLO): rd_data = DW'(cnt_lo);
      ADDR_W'(A_CNTHI): rd_data = DW'(cnt_hi);
      default:          rd_data = '0;
    endcase
  end

  assign irq_lo_o   = flag_lo_q;
  assign irq_hi_o   = flag_hi_q;
  assign match_lo_o = plo_q;
  assign match_hi_o = phi_q;
endmodule

// File: rtl/split_timer16_chk.sv
module split_timer16_chk #(
  parameter int HALF_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_wr,
  input logic [1:0]        mode,
  input logic              hit_lo,
  input logic              hit_hi,
  input logic [HALF_W-1:0] cnt_lo,
  input logic [HALF_W-1:0] cnt_hi,
  input logic              flag_lo,
  input logic              flag_hi,
  input logic              clr_lo,
  input logic              clr_hi,
  input logic              pulse_lo,
  input logic              pulse_hi
);
  AST_CTRL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt_lo == '0 && cnt_hi == '0)); // R11
  AST_LO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && hit_lo) |=> (cnt_lo == '0)); // R7
  AST_HI_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_wr && hit_hi) |=> (cnt_hi == '0)); // R7
  AST_PULSE_LO: assert property (@(posedge clk) disable iff (!rst_n)
    hit_lo |=> (pulse_lo && flag_lo)); // R7
  AST_PULSE_HI: assert property (@(posedge clk) disable iff (!rst_n)
    hit_hi |=> (pulse_hi && flag_hi)); // R7
  AST_FLAG_HOLD_LO: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_lo && !clr_lo) |=> flag_lo); // R8
  AST_FLAG_HOLD_HI: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_hi && !clr_hi) |=> flag_hi); // R8
  AST_HI_CASCADE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[1] && !ctrl_wr && !hit_lo) |=> $stable(cnt_hi)); // R5
endmodule

bind split_timer16 split_timer16_chk #(.HALF_W(HALF_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_wr (ctrl_wr),
  .mode    (mode_q),
  .hit_lo  (hit_lo),
  .hit_hi  (hit_hi),
  .cnt_lo  (cnt_lo),
  .cnt_hi  (cnt_hi),
  .flag_lo (irq_lo_o),
  .flag_hi (irq_hi_o),
  .clr_lo  (flag_clr_lo),
  .clr_hi  (flag_clr_hi),
  .pulse_lo(match_lo_o),
  .pulse_hi(match_hi_o)
);

// File: tb/sim_split_timer16.sv
`timescale 1ns/1ps
module sim_split_timer16;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [3:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [3:0] ins = '0;  // 0 evt_lo, 1 evt_hi, 2 cap_lo, 3 cap_hi
  logic irq_lo, irq_hi, mp_lo, mp_hi;

  always #2 clk = ~clk;

  split_timer16 u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_lo_i(ins[0]), .evt_hi_i(ins[1]), .cap_lo_i(ins[2]), .cap_hi_i(ins[3]),
    .irq_lo_o(irq_lo), .irq_hi_o(irq_hi), .match_lo_o(mp_lo), .match_hi_o(mp_hi)
  );

  int checks = 0, errors = 0;
  bit fin = 0;
  string cur_req = "R1";

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_mode = 0, m_rlo = 0, m_rhi = 0, m_psv = 0, m_mlo = 255, m_mhi = 255;
  int m_flo = 0, m_fhi = 0, m_clo = 0, m_chi = 0, m_cplo = 0, m_cphi = 0;
  int m_pc = 0, m_plo = 0, m_phi = 0;
  int past [4][$];
  int rs [4];
  int tk, ilo, ihi, hlo, hhi, cw, fw;

  initial for (int i = 0; i < 4; i++) past[i] = '{0, 0, 0};

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_rlo = 0; m_rhi = 0; m_psv = 0; m_mlo = 255; m_mhi = 255;
      m_flo = 0; m_fhi = 0; m_clo = 0; m_chi = 0; m_cplo = 0; m_cphi = 0;
      m_pc = 0; m_plo = 0; m_phi = 0;
      for (int i = 0; i < 4; i++) past[i] = '{0, 0, 0};
    end else begin
      for (int i = 0; i < 4; i++) begin
        rs[i] = (past[i][1] == 1 && past[i][2] == 0) ? 1 : 0;
        past[i].push_front(int'(ins[i]));
        void'(past[i].pop_back());
      end
      tk = (m_pc == m_psv);
      case (m_mode)
        0: begin ilo = m_rlo && tk; ihi = m_rhi && tk; end
        1: begin ilo = m_rlo && tk; ihi = m_rhi && rs[1]; end
        2: begin ilo = m_rlo && tk; ihi = 0; end
        default: begin ilo = m_rlo && rs[0]; ihi = 0; end
      endcase
      hlo = ilo && (m_clo == m_mlo);
      if (m_mode >= 2) ihi = hlo;
      hhi = ihi && (m_chi == m_mhi);
      cw = wr_en && wr_addr == 0;
      fw = wr_en && wr_addr == 4;
      if (rs[2]) m_cplo = m_clo;
      if ((m_mode >= 2) ? rs[2] : rs[3]) m_cphi = m_chi;
      m_flo = hlo || (m_flo && !(fw && wr_data[0]));
      m_fhi = hhi || (m_fhi && !(fw && wr_data[1]));
      m_plo = hlo; m_phi = hhi;
      if (cw) begin
        m_clo = 0; m_chi = 0; m_pc = 0;
        m_mode = wr_data[1:0]; m_rlo = wr_data[2]; m_rhi = wr_data[3];
      end else begin
        m_pc  = tk ? 0 : (m_pc + 1) % 256;
        m_clo = hlo ? 0 : (ilo ? m_clo + 1 : m_clo);
        m_chi = hhi ? 0 : (ihi ? m_chi + 1 : m_chi);
      end
      if (wr_en && wr_addr == 1) m_psv = wr_data;
      if (wr_en && wr_addr == 2) m_mlo = wr_data;
      if (wr_en && wr_addr == 3) m_mhi = wr_data;
    end
  end

  function automatic int exp_rd(int a);
    case (a)
      0: return m_rhi * 8 + m_rlo * 4 + m_mode;
      1: return m_psv;
      2: return m_mlo;
      3: return m_mhi;
      4: return m_fhi * 2 + m_flo;
      5: return m_cplo;
      6: return m_cphi;
      7: return m_clo;
      8: return m_chi;
      default: return 0;
    endcase
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      chk(int'(rd_data) == exp_rd(int'(rd_addr)), cur_req, int'(rd_data), exp_rd(int'(rd_addr)));
      chk({irq_hi, irq_lo, mp_hi, mp_lo} == 4'(m_fhi * 8 + m_flo * 4 + m_phi * 2 + m_plo),
          cur_req, int'({irq_hi, irq_lo, mp_hi, mp_lo}),
          m_fhi * 8 + m_flo * 4 + m_phi * 2 + m_plo);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic pulse(int i, int h, int l);
    ins[i] = 1'b1;
    idle(h);
    ins[i] = 1'b0;
    idle(l);
  endtask

  task automatic expect_rd(int a, int e, string tag);
    rd_addr = 4'(a);
    @(negedge clk);
    chk(int'(rd_data) == e, tag, int'(rd_data), e);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state and R12 map
    cur_req = "R1";
    expect_rd(0, 0, "R1");
    expect_rd(2, 255, "R1");
    expect_rd(3, 255, "R1");
    expect_rd(7, 0, "R1");
    expect_rd(9, 0, "R12");
    chk(irq_lo == 0 && irq_hi == 0, "R1", int'({irq_hi, irq_lo}), 0);

    // R2 prescaler period: divide by 4
    cur_req = "R2";
    wr(1, 3);
    wr(0, 8'h04);
    idle(40);
    expect_rd(7, 10, "R2");

    // R3 mode 0, two prescaled halves
    cur_req = "R3";
    wr(1, 1); wr(3, 2); wr(4, 3);
    rd_addr = 8;
    wr(0, 8'h0C);
    idle(5);
    chk(int'(rd_data) == 2, "R3", int'(rd_data), 2);
    idle(1);
    chk(int'(rd_data) == 0 && irq_hi == 1, "R3", int'(rd_data) + 100 * irq_hi, 100);
    idle(30);

    // R4 mode 1, high half counts events
    cur_req = "R4";
    wr(3, 255);
    wr(0, 8'h0D);
    pulse(1, 1, 1); pulse(1, 2, 3); pulse(1, 1, 5);
    expect_rd(8, 3, "R4");

    // R5 mode 2 cascade and high wrap
    cur_req = "R5";
    wr(1, 0); wr(2, 3); wr(3, 1); wr(4, 3);
    wr(0, 8'h06);
    idle(7);
    chk(irq_hi == 0, "R5", irq_hi, 0);
    idle(1);
    chk(irq_hi == 1, "R5", irq_hi, 1);
    idle(40);

    // R6 mode 3 event counting, evt_hi ignored
    cur_req = "R6";
    wr(2, 255); wr(3, 255);
    wr(0, 8'h07);
    for (int k = 0; k < 5; k++) begin
      ins[1] = 1'b1;
      pulse(0, 1, 1);
      ins[1] = 1'b0;
    end
    idle(4);
    expect_rd(7, 5, "R6");
    expect_rd(8, 0, "R6");

    // R10 long pulse counted once
    cur_req = "R10";
    pulse(0, 6, 4);
    expect_rd(7, 6, "R10");

    // R8 flag set, W1C clear of one half
    cur_req = "R8";
    wr(2, 2);
    wr(0, 8'h04);
    idle(10);
    chk(irq_lo == 1, "R8", irq_lo, 1);
    wr(2, 255);
    wr(4, 1);
    chk(irq_lo == 0, "R8", irq_lo, 0);

    // R9 capture in mode 0
    cur_req = "R9";
    wr(1, 0);
    wr(0, 8'h04);
    idle(10);
    pulse(2, 1, 6);
    expect_rd(5, 12, "R9");

    // R9 capture in mode 2 latches both halves; cap_hi ignored
    wr(2, 3);
    wr(0, 8'h06);
    idle(10);
    pulse(2, 1, 6);
    expect_rd(6, 3, "R9");
    expect_rd(5, 0, "R9");
    pulse(3, 2, 6);
    expect_rd(6, 3, "R9");

    // R11 control write clears counts mid-run
    cur_req = "R11";
    wr(0, 8'h06);
    chk(int'(rd_data) == 0 || rd_addr != 7, "R11", 0, 0);
    rd_addr = 7;
    @(negedge clk);
    chk(int'(rd_data) <= 1, "R11", int'(rd_data), 1);
    #1;

    // R7 match pulses under a mixed run
    cur_req = "R7";
    wr(2, 1); wr(3, 2);
    wr(0, 8'h0C);
    for (int k = 0; k < 60; k++) begin
      rd_addr = 4'(k % 9);
      ins[0] = k[1]; ins[1] = k[2];
      idle(1);
    end
    ins = '0;
    wr(0, 8'h0D);
    for (int k = 0; k < 40; k++) begin
      ins[1] = k[0]; ins[3] = k[2];
      rd_addr = 4'(k % 9);
      idle(1);
    end
    ins = '0;
    idle(5);

    fin = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule